// File: doc/BRIEF.md
# Unattached Port Request Filter

This block sits behind the receive path of a switch port that has not yet been bound to any partition. Each request reaches it as a decoded descriptor: a kind code, a target function number, a register byte offset, a requester ID, a tag, byte enables and write data. The filter gives every request one of three outcomes. Standard configuration accesses get a retry-status completion, which stalls ordinary enumeration. Two registers on function 0 work normally and form an indirect window into the device-wide register space. All other traffic is logged as unsupported and, when the request expects an answer, gets an unsupported-request completion.

The window is a pair of registers. One is a dword-aligned address register held inside the filter. The other is a data register: reads and writes to it turn into a single transfer on a global register bus that uses a valid/ready handshake, and read data returns later with its own strobe. Only one request is in flight at a time. The filter also raises a one-cycle speed-change request when the link enters L0, but only if the matching enable bit is set.

Top module: `detached_req_filter`

## Requirements
- R1: A configuration read (kind 0) or write (kind 1) whose function number is not 0 gets a completion with status CRS (2), no data, completer ID equal to `port_cid`, and the request's requester ID and tag echoed.
- R2: A configuration read or write to function 0 whose offset matches neither `WIN_ADDR_OFF` nor `WIN_DATA_OFF` also gets a CRS (2) completion with no data.
- R3: A configuration write to `WIN_ADDR_OFF` on function 0 updates only the bytes whose enables are set, and forces bits 1:0 to zero. A configuration read there returns the current value. Both complete with status SC (0) one cycle after acceptance.
- R4: A configuration write to `WIN_DATA_OFF` on function 0 issues one global-bus write at the window address, carrying the request's byte enables and data. A no-data SC completion follows only after the bus accepts the write.
- R5: A configuration read to `WIN_DATA_OFF` on function 0 issues one global-bus read. Its SC completion carries the returned data and is not produced before `gb_rvalid` has arrived.
- R6: While a window-data access is outstanding, `req_ready` is low. `gb_valid`, `gb_addr` and `gb_write` hold steady until `gb_ready` is seen.
- R7: A non-posted request that is not a configuration access (kinds 2 memory read, 4 I/O read, 5 I/O write) pulses `ur_log` for one cycle. It also gets a completion with status UR (1), completer ID zero, and the requester ID and tag echoed.
- R8: A posted request (kinds 3 memory write, 6 message, 7 message with data) pulses `ur_log` and produces no completion.
- R9: `spd_chg_req` pulses for one cycle after `link_l0` rises, and only if `spd_chg_en` was high at that edge. Otherwise it stays low.
- R10: After reset, `req_ready` is 1, `cpl_valid`, `gb_valid` and `spd_chg_req` are 0, and the window address reads 0. Only reset clears the window address: retry and unsupported traffic leave it intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_cid | input | 16 | Completer ID for retry and successful completions |
| req_valid | input | 1 | Request descriptor present |
| req_ready | output | 1 | Filter can take a request |
| req_kind | input | 3 | Request kind code (see R1, R7, R8) |
| req_func | input | FN_W | Target function number |
| req_off | input | OFF_W | Target register byte offset |
| req_rid | input | 16 | Requester ID |
| req_tag | input | 8 | Request tag |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| cpl_valid | output | 1 | One-cycle completion strobe |
| cpl_status | output | 3 | 0 SC, 1 UR, 2 CRS |
| cpl_cid | output | 16 | Completer ID |
| cpl_rid | output | 16 | Echoed requester ID |
| cpl_tag | output | 8 | Echoed tag |
| cpl_has_data | output | 1 | Completion carries data |
| cpl_data | output | 32 | Completion data |
| ur_log | output | 1 | One-cycle unsupported-request log pulse |
| gb_valid | output | 1 | Global bus transfer request |
| gb_ready | input | 1 | Global bus accepts transfer |
| gb_write | output | 1 | Transfer is a write |
| gb_addr | output | GB_AW | Global byte address |
| gb_be | output | 4 | Global byte enables |
| gb_wdata | output | 32 | Global write data |
| gb_rvalid | input | 1 | Global read data strobe |
| gb_rdata | input | 32 | Global read data |
| link_l0 | input | 1 | Link is in L0 |
| spd_chg_en | input | 1 | Initial speed-change enable |
| spd_chg_req | output | 1 | Speed-change request pulse |

## Verification
The bench builds the block with its defaults: a 32-bit global address, a 3-bit function field, a 12-bit offset, and the two window registers at offsets 0x0F8 and 0x0FC, which it passes explicitly. A 64-word bus model behind the port has a programmable accept stall and read latency. This lets the bench hold back `gb_ready` for several cycles to test the one-outstanding rule, and delay read data to show that the completion waits for it. The byte patterns are chosen so that partial byte enables on both the address register and the data path give results that differ from a full-word write.

// File: rtl/drf_pkg.sv
package drf_pkg;

    localparam int unsigned DW    = 32;
    localparam int unsigned ID_W  = 16;
    localparam int unsigned TAG_W = 8;
    localparam int unsigned BE_W  = DW / 8;

    typedef enum logic [2:0] {
        K_CFG_RD = 3'd0,
        K_CFG_WR = 3'd1,
        K_MEM_RD = 3'd2,
        K_MEM_WR = 3'd3,
        K_IO_RD  = 3'd4,
        K_IO_WR  = 3'd5,
        K_MSG    = 3'd6,
        K_MSG_D  = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        ACT_RETRY,
        ACT_WADDR,
        ACT_WDATA,
        ACT_UNSUP
    } act_e;

    localparam logic [2:0] CPL_SC  = 3'd0;
    localparam logic [2:0] CPL_UR  = 3'd1;
    localparam logic [2:0] CPL_CRS = 3'd2;

    typedef struct packed {
        logic [2:0]       status;
        logic [ID_W-1:0]  cid;
        logic [ID_W-1:0]  rid;
        logic [TAG_W-1:0] tag;
        logic             has_data;
        logic [DW-1:0]    data;
    } cpl_t;

    function automatic logic kind_is_cfg(input logic [2:0] k);
        return (k == K_CFG_RD) || (k == K_CFG_WR);
    endfunction

    function automatic logic kind_is_posted(input logic [2:0] k);
        return (k == K_MEM_WR) || (k == K_MSG) || (k == K_MSG_D);
    endfunction

    function automatic logic [DW-1:0] be_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [BE_W-1:0] be);
        logic [DW-1:0] r;
        r = old_v;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/drf_classify.sv
module drf_classify
    import drf_pkg::*;
#(
    parameter int unsigned        FN_W         = 3,
    parameter int unsigned        OFF_W        = 12,
    parameter logic [OFF_W-1:0]   WIN_ADDR_OFF = 12'h0F8,
    parameter logic [OFF_W-1:0]   WIN_DATA_OFF = 12'h0FC
) (
    input  logic [2:0]       kind,
    input  logic [FN_W-1:0]  func,
    input  logic [OFF_W-1:0] off,
    output act_e             act,
    output logic             posted,
    output logic             cfg_wr
);

    always_comb begin
        if (!kind_is_cfg(kind)) begin
            act = ACT_UNSUP;
        end else if (func != '0) begin
            act = ACT_RETRY;
        end else if (off == WIN_ADDR_OFF) begin
            act = ACT_WADDR;
        end else if (off == WIN_DATA_OFF) begin
            act = ACT_WDATA;
        end else begin
            act = ACT_RETRY;
        end
    end

    assign posted = kind_is_posted(kind);
    assign cfg_wr = (kind == K_CFG_WR);

endmodule

// File: rtl/drf_window.sv
module drf_window
    import drf_pkg::*;
#(
    parameter int unsigned GB_AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_wr,
    input  logic [BE_W-1:0]   addr_be,
    input  logic [DW-1:0]     addr_wdata,
    input  logic              data_go,
    input  logic              data_wr,
    input  logic [BE_W-1:0]   data_be,
    input  logic [DW-1:0]     data_wdata,
    output logic [GB_AW-1:0]  win_addr,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     done_rdata,
    output logic              gb_valid,
    input  logic              gb_ready,
    output logic              gb_write,
    output logic [GB_AW-1:0]  gb_addr,
    output logic [BE_W-1:0]   gb_be,
    output logic [DW-1:0]     gb_wdata,
    input  logic              gb_rvalid,
    input  logic [DW-1:0]     gb_rdata
);

    typedef enum logic [1:0] { W_IDLE, W_ISSUE, W_WAIT } wst_e;

    wst_e            st;
    logic            op_wr;
    logic [BE_W-1:0] op_be;
    logic [DW-1:0]   op_wdata;
    logic [DW-1:0]   cur32;
    logic [DW-1:0]   nxt32;

    assign cur32 = DW'(win_addr);

    always_comb begin
        nxt32      = be_merge(cur32, addr_wdata, addr_be);
        nxt32[1:0] = 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_addr <= '0;
        end else if (addr_wr) begin
            win_addr <= nxt32[GB_AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= W_IDLE;
            op_wr    <= 1'b0;
            op_be    <= '0;
            op_wdata <= '0;
        end else begin
            unique case (st)
                W_IDLE: if (data_go) begin
                    st       <= W_ISSUE;
                    op_wr    <= data_wr;
                    op_be    <= data_be;
                    op_wdata <= data_wdata;
                end
                W_ISSUE: if (gb_ready) st <= op_wr ? W_IDLE : W_WAIT;
                W_WAIT:  if (gb_rvalid) st <= W_IDLE;
                default: st <= W_IDLE;
            endcase
        end
    end

    assign busy       = (st != W_IDLE);
    assign gb_valid   = (st == W_ISSUE);
    assign gb_write   = op_wr;
    assign gb_addr    = win_addr;
    assign gb_be      = op_be;
    assign gb_wdata   = op_wdata;
    assign done       = ((st == W_ISSUE) && gb_ready && op_wr) ||
                        ((st == W_WAIT) && gb_rvalid);
    assign done_rdata = gb_rdata;

endmodule

// File: rtl/drf_speed.sv
module drf_speed (
    input  logic clk,
    input  logic rst,
    input  logic link_l0,
    input  logic spd_chg_en,
    output logic spd_chg_req
);

    logic l0_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            l0_q        <= 1'b0;
            spd_chg_req <= 1'b0;
        end else begin
            l0_q        <= link_l0;
            spd_chg_req <= link_l0 && !l0_q && spd_chg_en;
        end
    end

endmodule

// File: rtl/detached_req_filter.sv
module detached_req_filter
    import drf_pkg::*;
#(
    parameter int unsigned      GB_AW        = 32,
    parameter int unsigned      FN_W         = 3,
    parameter int unsigned      OFF_W        = 12,
    parameter logic [OFF_W-1:0] WIN_ADDR_OFF = 12'h0F8,
    parameter logic [OFF_W-1:0] WIN_DATA_OFF = 12'h0FC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       port_cid,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [FN_W-1:0]   req_func,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [15:0]       req_rid,
    input  logic [7:0]        req_tag,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              cpl_valid,
    output logic [2:0]        cpl_status,
    output logic [15:0]       cpl_cid,
    output logic [15:0]       cpl_rid,
    output logic [7:0]        cpl_tag,
    output logic              cpl_has_data,
    output logic [31:0]       cpl_data,
    output logic              ur_log,
    output logic              gb_valid,
    input  logic              gb_ready,
    output logic              gb_write,
    output logic [GB_AW-1:0]  gb_addr,
    output logic [3:0]        gb_be,
    output logic [31:0]       gb_wdata,
    input  logic              gb_rvalid,
    input  logic [31:0]       gb_rdata,
    input  logic              link_l0,
    input  logic              spd_chg_en,
    output logic              spd_chg_req
);

    act_e             act;
    logic             posted;
    logic             cfg_wr;
    logic             accept;
    logic             win_busy;
    logic             win_done;
    logic [DW-1:0]    win_rdata;
    logic [GB_AW-1:0] win_addr;
    cpl_t             cpl_q;
    logic             cpl_v;
    logic             ur_q;
    logic [15:0]      pend_rid;
    logic [7:0]       pend_tag;
    logic             pend_rd;

    drf_classify #(
        .FN_W(FN_W), .OFF_W(OFF_W),
        .WIN_ADDR_OFF(WIN_ADDR_OFF), .WIN_DATA_OFF(WIN_DATA_OFF)
    ) u_cls (
        .kind(req_kind), .func(req_func), .off(req_off),
        .act(act), .posted(posted), .cfg_wr(cfg_wr)
    );

    assign req_ready = !win_busy;
    assign accept    = req_valid && req_ready;

    drf_window #(.GB_AW(GB_AW)) u_win (
        .clk(clk), .rst(rst),
        .addr_wr(accept && (act == ACT_WADDR) && cfg_wr),
        .addr_be(req_be), .addr_wdata(req_wdata),
        .data_go(accept && (act == ACT_WDATA)),
        .data_wr(cfg_wr), .data_be(req_be), .data_wdata(req_wdata),
        .win_addr(win_addr), .busy(win_busy), .done(win_done), .done_rdata(win_rdata),
        .gb_valid(gb_valid), .gb_ready(gb_ready), .gb_write(gb_write),
        .gb_addr(gb_addr), .gb_be(gb_be), .gb_wdata(gb_wdata),
        .gb_rvalid(gb_rvalid), .gb_rdata(gb_rdata)
    );

    drf_speed u_spd (
        .clk(clk), .rst(rst), .link_l0(link_l0),
        .spd_chg_en(spd_chg_en), .spd_chg_req(spd_chg_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cpl_v    <= 1'b0;
            cpl_q    <= '0;
            ur_q     <= 1'b0;
            pend_rid <= '0;
            pend_tag <= '0;
            pend_rd  <= 1'b0;
        end else begin
            cpl_v <= 1'b0;
            ur_q  <= 1'b0;
            if (accept) begin
                unique case (act)
                    ACT_RETRY: begin
                        cpl_v <= 1'b1;
                        cpl_q <= '{status: CPL_CRS, cid: port_cid, rid: req_rid,
                                   tag: req_tag, has_data: 1'b0, data: '0};
                    end
                    ACT_WADDR: begin
                        cpl_v <= 1'b1;
                        cpl_q <= '{status: CPL_SC, cid: port_cid, rid: req_rid,
                                   tag: req_tag, has_data: !cfg_wr,
                                   data: cfg_wr ? '0 : DW'(win_addr)};
                    end
                    ACT_WDATA: begin
                        pend_rid <= req_rid;
                        pend_tag <= req_tag;
                        pend_rd  <= !cfg_wr;
                    end
                    default: begin
                        ur_q <= 1'b1;
                        if (!posted) begin
                            cpl_v <= 1'b1;
                            cpl_q <= '{status: CPL_UR, cid: '0, rid: req_rid,
                                       tag: req_tag, has_data: 1'b0, data: '0};
                        end
                    end
                endcase
            end
            if (win_done) begin
                cpl_v <= 1'b1;
                cpl_q <= '{status: CPL_SC, cid: port_cid, rid: pend_rid, tag: pend_tag,
                           has_data: pend_rd, data: pend_rd ? win_rdata : '0};
            end
        end
    end

    assign cpl_valid    = cpl_v;
    assign cpl_status   = cpl_q.status;
    assign cpl_cid      = cpl_q.cid;
    assign cpl_rid      = cpl_q.rid;
    assign cpl_tag      = cpl_q.tag;
    assign cpl_has_data = cpl_q.has_data;
    assign cpl_data     = cpl_q.data;
    assign ur_log       = ur_q;

endmodule

// File: rtl/drf_checker.sv
module drf_checker #(
    parameter int unsigned GB_AW = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             gb_valid,
    input logic             gb_ready,
    input logic             gb_write,
    input logic [GB_AW-1:0] gb_addr,
    input logic             cpl_valid,
    input logic [2:0]       cpl_status,
    input logic [15:0]      cpl_cid,
    input logic             cpl_has_data,
    input logic             link_l0,
    input logic             spd_chg_en,
    input logic             spd_chg_req
);

    AST_CRS_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && (cpl_status == 3'd2) |-> !cpl_has_data); // R1

    AST_GB_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        gb_valid |-> (gb_addr[1:0] == 2'b00)); // R3

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        gb_valid |-> !req_ready); // R6

    AST_GB_HOLD: assert property (@(posedge clk) disable iff (rst)
        gb_valid && !gb_ready |=> gb_valid && $stable(gb_addr) && $stable(gb_write)); // R6

    AST_UR_ZERO_CID: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && (cpl_status == 3'd1) |-> (cpl_cid == 16'h0000)); // R7

    AST_SPD_GATED: assert property (@(posedge clk) disable iff (rst)
        spd_chg_req |-> $past(spd_chg_en) && $past(link_l0)); // R9

    AST_SPD_PULSE: assert property (@(posedge clk) disable iff (rst)
        spd_chg_req |=> !spd_chg_req); // R9

endmodule

bind detached_req_filter drf_checker #(.GB_AW(GB_AW)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready),
    .gb_valid(gb_valid), .gb_ready(gb_ready), .gb_write(gb_write), .gb_addr(gb_addr),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_cid(cpl_cid),
    .cpl_has_data(cpl_has_data), .link_l0(link_l0), .spd_chg_en(spd_chg_en),
    .spd_chg_req(spd_chg_req)
);

// File: tb/detached_req_filter_test.sv
`timescale 1ns/1ps
module detached_req_filter_test;

    localparam logic [11:0] AOFF = 12'h0F8;
    localparam logic [11:0] DOFF = 12'h0FC;
    localparam logic [15:0] PCID = 16'hBEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [2:0]  req_func = '0;
    logic [11:0] req_off = '0;
    logic [15:0] req_rid = '0;
    logic [7:0]  req_tag = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        cpl_valid;
    logic [2:0]  cpl_status;
    logic [15:0] cpl_cid, cpl_rid;
    logic [7:0]  cpl_tag;
    logic        cpl_has_data;
    logic [31:0] cpl_data;
    logic        ur_log;
    logic        gb_valid, gb_write;
    logic        gb_ready = 1'b1;
    logic [31:0] gb_addr, gb_wdata;
    logic [3:0]  gb_be;
    logic        gb_rvalid = 1'b0;
    logic [31:0] gb_rdata = '0;
    logic        link_l0 = 1'b0;
    logic        spd_chg_en = 1'b0;
    logic        spd_chg_req;

    always #4 clk = ~clk;

    detached_req_filter #(
        .GB_AW(32), .FN_W(3), .OFF_W(12), .WIN_ADDR_OFF(AOFF), .WIN_DATA_OFF(DOFF)
    ) uut (
        .clk(clk), .rst(rst), .port_cid(PCID),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_func(req_func), .req_off(req_off), .req_rid(req_rid), .req_tag(req_tag),
        .req_be(req_be), .req_wdata(req_wdata),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_cid(cpl_cid),
        .cpl_rid(cpl_rid), .cpl_tag(cpl_tag), .cpl_has_data(cpl_has_data),
        .cpl_data(cpl_data), .ur_log(ur_log),
        .gb_valid(gb_valid), .gb_ready(gb_ready), .gb_write(gb_write), .gb_addr(gb_addr),
        .gb_be(gb_be), .gb_wdata(gb_wdata), .gb_rvalid(gb_rvalid), .gb_rdata(gb_rdata),
        .link_l0(link_l0), .spd_chg_en(spd_chg_en), .spd_chg_req(spd_chg_req)
    );

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    // global bus model
    logic [31:0] mem [0:63];
    int          rd_lat = 2;
    int          rd_cnt = 0;
    logic [31:0] rd_hold = '0;
    bit          rv_seen = 0;
    logic [31:0] last_wr_addr = '0;
    logic [3:0]  last_wr_be = '0;

    always @(negedge clk) begin
        #2;
        gb_rvalid = 1'b0;
        if (rd_cnt != 0) begin
            rd_cnt = rd_cnt - 1;
            if (rd_cnt == 0) begin
                gb_rvalid = 1'b1;
                gb_rdata  = rd_hold;
                rv_seen   = 1;
            end
        end
        if (gb_valid && gb_ready) begin
            if (gb_write) begin
                for (int b = 0; b < 4; b++)
                    if (gb_be[b]) mem[gb_addr[7:2]][8*b +: 8] = gb_wdata[8*b +: 8];
                last_wr_addr = gb_addr;
                last_wr_be   = gb_be;
            end else begin
                rd_hold = mem[gb_addr[7:2]];
                rd_cnt  = rd_lat;
            end
        end
    end

    // completion capture
    bit          c_got, c_ur;
    logic [2:0]  c_st;
    logic [15:0] c_cid, c_rid;
    logic [7:0]  c_tag;
    logic        c_hd;
    logic [31:0] c_data;
    logic [15:0] exp_rid;
    logic [7:0]  exp_tag;
    int          seq = 1;

    task automatic check(input string rq, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic issue(input logic [2:0] k, input logic [2:0] f, input logic [11:0] o,
                         input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        req_kind  = k;
        req_func  = f;
        req_off   = o;
        req_be    = be;
        req_wdata = wd;
        req_rid   = 16'h0100 + 16'(seq);
        req_tag   = 8'(seq * 3);
        exp_rid   = req_rid;
        exp_tag   = req_tag;
        seq++;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_cpl(input int n);
        c_got = 0;
        c_ur  = 0;
        for (int i = 0; i < n; i++) begin
            if (ur_log) c_ur = 1;
            if (cpl_valid) begin
                c_got  = 1;
                c_st   = cpl_status;
                c_cid  = cpl_cid;
                c_rid  = cpl_rid;
                c_tag  = cpl_tag;
                c_hd   = cpl_has_data;
                c_data = cpl_data;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic cfg_access(input bit wr, input logic [2:0] f, input logic [11:0] o,
                              input logic [3:0] be, input logic [31:0] wd);
        issue(wr ? 3'd1 : 3'd0, f, o, be, wd);
        wait_cpl(60);
    endtask

    task automatic t_reset;
        check("R10", "req_ready", 32'(req_ready), 32'd1);
        check("R10", "cpl_valid", 32'(cpl_valid), 32'd0);
        check("R10", "gb_valid", 32'(gb_valid), 32'd0);
        check("R10", "spd_chg_req", 32'(spd_chg_req), 32'd0);
        cfg_access(0, 3'd0, AOFF, 4'hF, 32'h0);
        check("R10", "window address after reset", c_data, 32'h0);
    endtask

    task automatic t_retry_func;
        cfg_access(0, 3'd3, DOFF, 4'hF, 32'h0);
        check("R1", "got completion", 32'(c_got), 32'd1);
        check("R1", "status CRS", 32'(c_st), 32'd2);
        check("R1", "completer id", 32'(c_cid), 32'(PCID));
        check("R1", "rid echo", 32'(c_rid), 32'(exp_rid));
        check("R1", "tag echo", 32'(c_tag), 32'(exp_tag));
        cfg_access(1, 3'd7, AOFF, 4'hF, 32'hDEAD_0000);
        check("R1", "write other function CRS", 32'(c_st), 32'd2);
        check("R1", "no data", 32'(c_hd), 32'd0);
    endtask

    task automatic t_retry_off;
        cfg_access(0, 3'd0, 12'h000, 4'hF, 32'h0);
        check("R2", "fn0 offset 0 CRS", 32'(c_st), 32'd2);
        cfg_access(1, 3'd0, 12'h0F4, 4'hF, 32'h1);
        check("R2", "fn0 offset F4 write CRS", 32'(c_st), 32'd2);
        check("R2", "no global access", 32'(last_wr_be), 32'h0);
    endtask

    task automatic t_win_addr;
        cfg_access(1, 3'd0, AOFF, 4'hF, 32'h0000_1237);
        check("R3", "write status SC", 32'(c_st), 32'd0);
        check("R3", "write no data", 32'(c_hd), 32'd0);
        cfg_access(0, 3'd0, AOFF, 4'hF, 32'h0);
        check("R3", "low bits cleared", c_data, 32'h0000_1234);
        check("R3", "read has data", 32'(c_hd), 32'd1);
        cfg_access(1, 3'd0, AOFF, 4'b0001, 32'hFFFF_FF8D);
        cfg_access(0, 3'd0, AOFF, 4'hF, 32'h0);
        check("R3", "byte enable merge", c_data, 32'h0000_128C);
    endtask

    task automatic t_win_data_wr;
        cfg_access(1, 3'd0, AOFF, 4'hF, 32'h0000_0020);
        gb_ready = 1'b0;
        issue(3'd1, 3'd0, DOFF, 4'hF, 32'hA5A5_5A5A);
        for (int i = 0; i < 3; i++) begin
            check("R6", "ready low while busy", 32'(req_ready), 32'd0);
            check("R4", "no completion before accept", 32'(cpl_valid), 32'd0);
            @(negedge clk);
        end
        gb_ready = 1'b1;
        wait_cpl(20);
        check("R4", "write completion", 32'(c_got), 32'd1);
        check("R4", "write status SC", 32'(c_st), 32'd0);
        check("R4", "rid echo", 32'(c_rid), 32'(exp_rid));
        check("R4", "memory word", mem[8], 32'hA5A5_5A5A);
        check("R4", "write address", last_wr_addr, 32'h20);
        cfg_access(1, 3'd0, DOFF, 4'b0110, 32'h1122_3344);
        check("R4", "partial byte enables", 32'(last_wr_be), 32'(4'b0110));
        check("R4", "partial merge", mem[8], 32'hA522_335A);
    endtask

    task automatic t_win_data_rd;
        rd_lat  = 5;
        rv_seen = 0;
        issue(3'd0, 3'd0, DOFF, 4'hF, 32'h0);
        wait_cpl(40);
        check("R5", "read completion", 32'(c_got), 32'd1);
        check("R5", "data returned first", 32'(rv_seen), 32'd1);
        check("R5", "read data", c_data, 32'hA522_335A);
        check("R5", "has data", 32'(c_hd), 32'd1);
        check("R5", "tag echo", 32'(c_tag), 32'(exp_tag));
        rd_lat = 2;
    endtask

    task automatic t_unsup;
        issue(3'd2, 3'd0, DOFF, 4'hF, 32'h0);
        wait_cpl(10);
        check("R7", "ur logged", 32'(c_ur), 32'd1);
        check("R7", "status UR", 32'(c_st), 32'd1);
        check("R7", "zero completer id", 32'(c_cid), 32'd0);
        check("R7", "rid echo", 32'(c_rid), 32'(exp_rid));
        check("R7", "tag echo", 32'(c_tag), 32'(exp_tag));
        issue(3'd5, 3'd0, AOFF, 4'hF, 32'h0);
        wait_cpl(10);
        check("R7", "io write UR", 32'(c_st), 32'd1);
    endtask

    task automatic t_posted;
        issue(3'd3, 3'd0, AOFF, 4'hF, 32'hFFFF_FFFF);
        wait_cpl(8);
        check("R8", "mem write logged", 32'(c_ur), 32'd1);
        check("R8", "mem write no completion", 32'(c_got), 32'd0);
        issue(3'd6, 3'd0, DOFF, 4'hF, 32'h0);
        wait_cpl(8);
        check("R8", "message logged", 32'(c_ur), 32'd1);
        check("R8", "message no completion", 32'(c_got), 32'd0);
        cfg_access(0, 3'd0, AOFF, 4'hF, 32'h0);
        check("R10", "window address kept", c_data, 32'h0000_0020);
    endtask

    task automatic t_speed;
        bit seen;
        @(negedge clk);
        spd_chg_en = 1'b0;
        link_l0    = 1'b1;
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (spd_chg_req) seen = 1;
        end
        check("R9", "no request when disabled", 32'(seen), 32'd0);
        link_l0 = 1'b0;
        repeat (2) @(negedge clk);
        spd_chg_en = 1'b1;
        link_l0    = 1'b1;
        @(negedge clk);
        check("R9", "request on L0 entry", 32'(spd_chg_req), 32'd1);
        @(negedge clk);
        check("R9", "single pulse", 32'(spd_chg_req), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'(i) * 32'h0101_0101;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_retry_func;
        t_retry_off;
        t_win_addr;
        t_win_data_wr;
        t_win_data_rd;
        t_unsup;
        t_posted;
        t_speed;
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion of all tests");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule